// File: doc/BRIEF.md
# Masked Register Write and Poll Unit

This unit carries out the two memory-facing operations of a command engine on a small register bus. The bus carries one transaction at a time and uses a request/acknowledge handshake plus a read-valid strobe. A write command stores a value at an address. When a partial bit mask is supplied, the unit first reads the old word, keeps the bits the mask leaves clear, and then writes the merged word back. A poll command reads one address again and again until the read data equals the target value on the masked bits. While a poll is running, a global stall output holds every thread of the engine.

A command can use one of two address forms, selected by bit 1 of its low address field. When that bit is set, it marks the long form: the upper half of the address comes from a special-purpose register that the engine supplies, and bit 1 is cleared before the address goes on the bus. When the bit is clear, the low field alone addresses a window at the bottom of the address space. Two configuration inputs set the number of idle cycles between poll reads and an optional limit on failed reads. The engine must hold both inputs stable while a command runs. Each finished command produces a one-cycle done pulse. An aborted poll also raises err in the same cycle.

Top module: `mask_poll_unit`

## Requirements
- R1: A write with cmd_use_mask low, or with a mask of all ones, makes exactly one bus write of cmd_value and no bus read.
- R2: A write with any other mask makes one bus read and then one bus write of (old & ~mask) | (value & mask).
- R3: A poll finishes when (read data & mask) equals (value & mask). With cmd_use_mask low, all 32 bits are compared.
- R4: Between a failed poll read's read-valid and the next read request there are exactly cfg_gap idle cycles. A cfg_gap of 0 issues the next read in the cycle right after.
- R5: When bit 1 of cmd_addr_lo is set, the bus address is {cmd_addr_hi, cmd_addr_lo with bit 1 cleared}. When it is clear, the bus address is {16'h0, cmd_addr_lo} and cmd_addr_hi has no effect. Bus address bit 1 is never set while a request is active.
- R6: stall_all is high from the cycle after a poll is accepted until the poll ends. It stays low for the whole of any write command.
- R7: With a nonzero cfg_limit, a poll whose cfg_limit-th read still mismatches ends with done and err together and releases the stall. A matching read ends the poll without err. A cfg_limit of 0 removes the limit.
- R8: bus_req, bus_addr, bus_we and bus_wdata stay unchanged until bus_ack. Each transaction raises bus_req once.
- R9: done is a single-cycle pulse, once per command. cmd_ready stays low while a command is in progress.
- R10: After reset the unit is idle: cmd_ready is high, and bus_req, stall_all, done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command taken this cycle |
| cmd_poll | input | 1 | 1 = poll, 0 = write |
| cmd_use_mask | input | 1 | Apply cmd_mask |
| cmd_addr_hi | input | 16 | Upper address half from the special-purpose register |
| cmd_addr_lo | input | 16 | Low address field; bit 1 selects the long form |
| cmd_value | input | 32 | Write data or poll target |
| cmd_mask | input | 32 | Bit mask |
| cfg_gap | input | 8 | Idle cycles between poll reads |
| cfg_limit | input | 8 | Failed-read limit, 0 = none |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Request accepted |
| bus_rvalid | input | 1 | Read data valid |
| bus_rdata | input | 32 | Read data |
| stall_all | output | 1 | Hold all engine threads |
| done | output | 1 | Command finished (pulse) |
| err | output | 1 | Poll aborted at limit (pulse) |

## Verification
Writes are swept over a set of masks: none, all ones, all zeros, alternating bits, single bits and half words. Each mask is applied to two old words. This separates the plain path (no read) from the merge path and catches inverted or swapped mask terms. Address forms alternate with the sweep, using a junk upper half in the short form to show it is ignored. Polls run against a register whose value counts up with every read, for every pairing of gap 0 to 3 and target 0 to 3. The number of reads and the measured spacing then pin down the match test and the interval. Masked targets, limits reached before and after a match, and a limit of one tell early abort apart from a match, and masked compare from full compare.

// File: rtl/mwp_pkg.sv
package mwp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_WR_REQ  = 3'd3,
    ST_GAP     = 3'd4
  } mwp_state_e;
endpackage

// File: rtl/mwp_addr_form.sv
module mwp_addr_form #(
  parameter int HI_W     = 16,
  parameter int LO_W     = 16,
  parameter int MARK_BIT = 1
) (
  input  logic [HI_W-1:0]      hi,
  input  logic [LO_W-1:0]      lo,
  output logic [HI_W+LO_W-1:0] addr
);
  logic [LO_W-1:0] lo_clr;
  logic            long_form;

  assign long_form = lo[MARK_BIT];

  always_comb begin
    lo_clr           = lo;
    lo_clr[MARK_BIT] = 1'b0;
  end

  // R5: long form takes the register-held upper half, short form a zero page
  assign addr = long_form ? {hi, lo_clr} : {{HI_W{1'b0}}, lo};
endmodule

// File: rtl/mwp_merge.sv
module mwp_merge #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] old_data,
  input  logic [DW-1:0] new_data,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] merged,
  output logic          hit
);
  assign merged = (old_data & ~mask) | (new_data & mask);
  assign hit    = ((old_data ^ new_data) & mask) == '0;
endmodule

// File: rtl/mwp_poll_timer.sv
module mwp_poll_timer #(
  parameter int GAP_W = 8,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             gap_load,
  input  logic [GAP_W-1:0] gap_val,
  input  logic             gap_tick,
  input  logic             miss,
  input  logic [LIM_W-1:0] limit,
  output logic             gap_done,
  output logic             limit_hit
);
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [LIM_W-1:0] miss_q, miss_d;
  logic             gap_en, miss_en;
  logic [LIM_W:0]   miss_next;

  always_comb begin
    gap_en = gap_load | gap_tick;
    gap_d  = gap_load ? gap_val : gap_q - 1'b1;
  end

  always_comb begin
    miss_en = start | (miss & (limit != '0));
    miss_d  = start ? '0 : miss_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (gap_en) gap_q <= gap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       miss_q <= '0;
    else if (miss_en) miss_q <= miss_d;
  end

  assign miss_next = {1'b0, miss_q} + 1'b1;
  assign gap_done  = (gap_q >> 1) == '0;
  assign limit_hit = (limit != '0) && (miss_next >= {1'b0, limit});

  // R4: the spacing counter is never ticked past zero
  a_r4_gap_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    gap_tick |-> gap_q != '0);

  // R7: failed reads never run beyond the limit
  a_r7_limit_not_passed: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && limit != '0) |-> miss_q < limit);
endmodule

// File: rtl/mask_poll_unit.sv
module mask_poll_unit
  import mwp_pkg::*;
#(
  parameter int DW       = 32,
  parameter int HI_W     = 16,
  parameter int LO_W     = 16,
  parameter int GAP_W    = 8,
  parameter int LIM_W    = 8,
  parameter int MARK_BIT = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic                 cmd_poll,
  input  logic                 cmd_use_mask,
  input  logic [HI_W-1:0]      cmd_addr_hi,
  input  logic [LO_W-1:0]      cmd_addr_lo,
  input  logic [DW-1:0]        cmd_value,
  input  logic [DW-1:0]        cmd_mask,
  input  logic [GAP_W-1:0]     cfg_gap,
  input  logic [LIM_W-1:0]     cfg_limit,
  output logic                 bus_req,
  output logic                 bus_we,
  output logic [HI_W+LO_W-1:0] bus_addr,
  output logic [DW-1:0]        bus_wdata,
  input  logic                 bus_ack,
  input  logic                 bus_rvalid,
  input  logic [DW-1:0]        bus_rdata,
  output logic                 stall_all,
  output logic                 done,
  output logic                 err
);
  localparam int AW = HI_W + LO_W;

  mwp_state_e    st_q, st_d;
  logic [AW-1:0] addr_q, cmd_addr;
  logic [DW-1:0] val_q, mask_q, wdata_q, wdata_d, merged;
  logic          poll_q, hit, is_plain;
  logic          load_cmd, load_merge, gap_load, gap_tick, miss;
  logic          gap_done, limit_hit;
  logic          done_d, err_d, done_q, err_q;

  mwp_addr_form #(.HI_W(HI_W), .LO_W(LO_W), .MARK_BIT(MARK_BIT)) u_addr (
    .hi   (cmd_addr_hi),
    .lo   (cmd_addr_lo),
    .addr (cmd_addr)
  );

  mwp_merge #(.DW(DW)) u_merge (
    .old_data (bus_rdata),
    .new_data (val_q),
    .mask     (mask_q),
    .merged   (merged),
    .hit      (hit)
  );

  mwp_poll_timer #(.GAP_W(GAP_W), .LIM_W(LIM_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (load_cmd),
    .gap_load  (gap_load),
    .gap_val   (cfg_gap),
    .gap_tick  (gap_tick),
    .miss      (miss),
    .limit     (cfg_limit),
    .gap_done  (gap_done),
    .limit_hit (limit_hit)
  );

  assign is_plain = !cmd_use_mask || (&cmd_mask);

  // next-state logic
  always_comb begin
    st_d       = st_q;
    load_cmd   = 1'b0;
    load_merge = 1'b0;
    gap_load   = 1'b0;
    gap_tick   = 1'b0;
    miss       = 1'b0;
    done_d     = 1'b0;
    err_d      = 1'b0;
    unique case (st_q)
      ST_IDLE: if (cmd_valid) begin
        load_cmd = 1'b1;
        st_d     = (cmd_poll || !is_plain) ? ST_RD_REQ : ST_WR_REQ;
      end
      ST_RD_REQ: if (bus_ack) st_d = ST_RD_WAIT;
      ST_RD_WAIT: if (bus_rvalid) begin
        if (!poll_q) begin
          load_merge = 1'b1;
          st_d       = ST_WR_REQ;
        end else if (hit) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          miss = 1'b1;
          if (limit_hit) begin
            done_d = 1'b1;
            err_d  = 1'b1;
            st_d   = ST_IDLE;
          end else if (cfg_gap == '0) begin
            st_d = ST_RD_REQ;
          end else begin
            gap_load = 1'b1;
            st_d     = ST_GAP;
          end
        end
      end
      ST_WR_REQ: if (bus_ack) begin
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      ST_GAP: begin
        gap_tick = 1'b1;
        if (gap_done) st_d = ST_RD_REQ;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign wdata_d = load_cmd ? cmd_value : merged;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      val_q  <= '0;
      mask_q <= '0;
      poll_q <= 1'b0;
    end else if (load_cmd) begin
      addr_q <= cmd_addr;
      val_q  <= cmd_value;
      mask_q <= cmd_use_mask ? cmd_mask : '1;
      poll_q <= cmd_poll;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      wdata_q <= '0;
    else if (load_cmd || load_merge) wdata_q <= wdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign cmd_ready = (st_q == ST_IDLE);
  assign bus_req   = (st_q == ST_RD_REQ) || (st_q == ST_WR_REQ);
  assign bus_we    = (st_q == ST_WR_REQ);
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign stall_all = poll_q && (st_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;

  // R8: request fields hold until accepted
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                               && $stable(bus_wdata)));

  // R5: the long-form marker never reaches the bus
  a_r5_marker_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !bus_addr[MARK_BIT]);

  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: err only ends a stalled poll, together with done
  a_r7_err_from_poll: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && $past(stall_all)));

  // R6: no command is taken while the threads are held
  a_r6_stall_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    stall_all |-> !cmd_ready);

  // R6: stall drops with the poll's completion
  a_r6_stall_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !stall_all);
endmodule

// File: tb/mask_poll_unit_test.sv
`timescale 1ns/1ps
module mask_poll_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready, cmd_poll, cmd_use_mask;
  logic [15:0] cmd_addr_hi, cmd_addr_lo;
  logic [31:0] cmd_value, cmd_mask;
  logic [7:0]  cfg_gap, cfg_limit;
  logic        bus_req, bus_we, bus_ack, bus_rvalid;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        stall_all, done, err;

  always #2.5 clk = ~clk;

  mask_poll_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_poll(cmd_poll), .cmd_use_mask(cmd_use_mask), .cmd_addr_hi(cmd_addr_hi),
    .cmd_addr_lo(cmd_addr_lo), .cmd_value(cmd_value), .cmd_mask(cmd_mask),
    .cfg_gap(cfg_gap), .cfg_limit(cfg_limit), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .stall_all(stall_all),
    .done(done), .err(err)
  );

  int tests = 0;
  int fails = 0;

  // bus model state
  logic [31:0] mem [logic [31:0]];
  int          n_rd, n_wr, n_rise, cyc, t_rv, gmin, gmax, g;
  logic        have_rv, req_prev;
  logic [31:0] poll_cnt, last_waddr, last_raddr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack    <= 1'b0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      req_prev   <= 1'b0;
    end else begin
      cyc = cyc + 1;
      bus_ack    <= bus_req && !bus_ack;
      bus_rvalid <= 1'b0;
      if (bus_req && !req_prev) begin
        n_rise = n_rise + 1;
        if (have_rv) begin
          g = cyc - t_rv - 1;
          if (g < gmin) gmin = g;
          if (g > gmax) gmax = g;
        end
      end
      if (bus_rvalid) begin
        have_rv = 1'b1;
        t_rv    = cyc;
      end
      if (bus_req && bus_ack) begin
        if (bus_we) begin
          mem[bus_addr] = bus_wdata;
          n_wr       = n_wr + 1;
          last_waddr = bus_addr;
        end else begin
          n_rd       = n_rd + 1;
          last_raddr = bus_addr;
          if (bus_addr[31:28] == 4'hC) begin
            bus_rdata <= poll_cnt;
            poll_cnt  = poll_cnt + 1;
          end else begin
            bus_rdata <= mem.exists(bus_addr) ? mem[bus_addr] : 32'h0;
          end
          bus_rvalid <= 1'b1;
        end
      end
      req_prev <= bus_req;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic got_err, stall_bad, busy_bad, done_after;

  task automatic run_cmd(input logic poll, input logic um, input logic [15:0] hi,
                         input logic [15:0] lo, input logic [31:0] v,
                         input logic [31:0] m, input logic [7:0] gp,
                         input logic [7:0] lim);
    int n;
    @(negedge clk);
    n_rd = 0; n_wr = 0; n_rise = 0; poll_cnt = 0; have_rv = 1'b0;
    gmin = 9999; gmax = -1;
    cmd_valid = 1'b1; cmd_poll = poll; cmd_use_mask = um; cmd_addr_hi = hi;
    cmd_addr_lo = lo; cmd_value = v; cmd_mask = m; cfg_gap = gp; cfg_limit = lim;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_addr_hi = 16'hDEAD; cmd_value = 32'h0BAD_0BAD;
    stall_bad = 1'b0; busy_bad = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      if (stall_all !== poll) stall_bad = 1'b1;
      if (cmd_ready !== 1'b0) busy_bad = 1'b1;
      @(negedge clk);
      n++;
    end
    if (n >= 5000) begin
      tests++; fails++;
      $display("FAIL R9: command never finished, actual 0 expected 1");
    end
    got_err = err;
    if (stall_all !== 1'b0) stall_bad = 1'b1;
    @(negedge clk);
    done_after = done;
  endtask

  function automatic logic [31:0] mask_of(input int j);
    case (j)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h0000_FFFF;
      3: return 32'hFF00_FF00;
      4: return 32'h8000_0001;
      5: return 32'h0F0F_0F0F;
      6: return 32'hAAAA_AAAA;
      7: return 32'h0000_0010;
      default: return 32'h0000_00FF;
    endcase
  endfunction

  initial begin
    #500000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc = 0; n_rd = 0; n_wr = 0; n_rise = 0; t_rv = 0; g = 0;
    gmin = 0; gmax = 0; have_rv = 1'b0; poll_cnt = 0;
    last_waddr = 0; last_raddr = 0;
    cmd_valid = 0; cmd_poll = 0; cmd_use_mask = 0; cmd_addr_hi = 0; cmd_addr_lo = 0;
    cmd_value = 0; cmd_mask = 0; cfg_gap = 0; cfg_limit = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 cmd_ready", {31'b0, cmd_ready}, 32'd1);
    chk("R10 bus_req", {31'b0, bus_req}, 32'd0);
    chk("R10 stall_all", {31'b0, stall_all}, 32'd0);
    chk("R10 done/err", {30'b0, done, err}, 32'd0);

    // write sweep: masks x old words, alternating address forms
    for (int j = 0; j < 9; j++) begin
      for (int k = 0; k < 2; k++) begin
        logic [31:0] m, em, old, v, ea, expv;
        logic [15:0] lo, hi, lo_cmd;
        logic        um, lng;
        m   = mask_of(j);
        um  = (j != 8);
        old = k[0] ? 32'hFFFF_0000 : 32'h1234_5678;
        v   = 32'hA5C3_0F96 ^ (32'h0101_0101 * j);
        lo  = 16'h0100 + 16'(j * 8 + k * 4);
        lng = j[0];
        hi  = lng ? 16'h1234 : 16'hBEEF;
        lo_cmd = lng ? (lo | 16'h0002) : lo;
        ea  = lng ? {16'h1234, lo} : {16'h0000, lo};
        mem[ea] = old;
        run_cmd(1'b0, um, hi, lo_cmd, v, m, 8'd0, 8'd0);
        em   = um ? m : 32'hFFFF_FFFF;
        expv = (old & ~em) | (v & em);
        if (em == 32'hFFFF_FFFF) begin
          chk("R1 stored word", mem[ea], expv);
          chk("R1 no read", n_rd, 0);
        end else begin
          chk("R2 merged word", mem[ea], expv);
          chk("R2 one read", n_rd, 1);
        end
        chk("R1/R2 one write", n_wr, 1);
        chk("R5 write address", last_waddr, ea);
        chk("R6 no stall on write", {31'b0, stall_bad}, 32'd0);
        chk("R9 ready low while busy", {31'b0, busy_bad}, 32'd0);
        chk("R9 done single pulse", {31'b0, done_after}, 32'd0);
        chk("R7 no err on write", {31'b0, got_err}, 32'd0);
        chk("R8 one request per transaction", n_rise, n_rd + n_wr);
      end
    end

    // poll sweep: gap x target on counting register (long form)
    for (int gp = 0; gp < 4; gp++) begin
      for (int t = 0; t < 4; t++) begin
        run_cmd(1'b1, 1'b0, 16'hC000, 16'h0022, 32'(t), 32'h0, 8'(gp), 8'd0);
        chk("R3 reads until match", n_rd, t + 1);
        chk("R5 poll address", last_raddr, 32'hC000_0020);
        if (t > 0) begin
          chk("R4 min spacing", gmin, gp);
          chk("R4 max spacing", gmax, gp);
        end
        chk("R6 stall held during poll", {31'b0, stall_bad}, 32'd0);
        chk("R7 no err", {31'b0, got_err}, 32'd0);
        chk("R9 done single pulse", {31'b0, done_after}, 32'd0);
        chk("R8 one request per read", n_rise, n_rd);
      end
    end

    // masked poll: only bit 2 compared
    run_cmd(1'b1, 1'b1, 16'hC000, 16'h0022, 32'hFFFF_FFFC, 32'h0000_0004, 8'd1, 8'd0);
    chk("R3 masked compare reads", n_rd, 5);
    chk("R3 masked no err", {31'b0, got_err}, 32'd0);

    // same target unmasked never matches: limit 8 aborts
    run_cmd(1'b1, 1'b0, 16'hC000, 16'h0022, 32'hFFFF_FFFC, 32'h0000_0004, 8'd1, 8'd8);
    chk("R7 abort reads", n_rd, 8);
    chk("R7 abort err", {31'b0, got_err}, 32'd1);
    chk("R6 stall released after abort", {31'b0, stall_bad}, 32'd0);

    // match before limit
    run_cmd(1'b1, 1'b0, 16'hC000, 16'h0022, 32'd1, 32'h0, 8'd2, 8'd3);
    chk("R7 match under limit reads", n_rd, 2);
    chk("R7 match under limit no err", {31'b0, got_err}, 32'd0);

    // limit of one: match wins, mismatch aborts at once
    run_cmd(1'b1, 1'b0, 16'hC000, 16'h0022, 32'd0, 32'h0, 8'd0, 8'd1);
    chk("R7 limit one match reads", n_rd, 1);
    chk("R7 limit one match no err", {31'b0, got_err}, 32'd0);
    run_cmd(1'b1, 1'b0, 16'hC000, 16'h0022, 32'd5, 32'h0, 8'd0, 8'd1);
    chk("R7 limit one abort reads", n_rd, 1);
    chk("R7 limit one abort err", {31'b0, got_err}, 32'd1);

    // short form poll: upper half ignored
    mem[32'h0000_0040] = 32'h0000_0077;
    run_cmd(1'b1, 1'b0, 16'hC000, 16'h0040, 32'h0000_0077, 32'h0, 8'd0, 8'd0);
    chk("R5 short form address", last_raddr, 32'h0000_0040);
    chk("R3 short form reads", n_rd, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule